// File: doc/BRIEF.md
# Bus ready synchronizer

This block takes a set of asynchronous bus-ready requests from devices on the system data bus and produces one ready signal for the processor, aligned to the processor clock. A device raises its request when it has finished its data transfer. Each request has its own active-low enable, so in a multi-master system only the master that currently owns the bus lets its ready line through. The qualified requests are ORed together before synchronization.

A mode input picks the synchronization scheme. In double mode a rising request passes a rising-edge flop and then a falling-edge flop. A falling request skips the first flop, so a wait state takes effect one edge sooner. In single mode both directions pass only the falling-edge flop. A separate flop turns an active-low reset request into an active-high processor reset on the falling clock edge. An active-low power-up reset clears every flop.

Top module: `bus_rdy_sync`

## Requirements
- R1: Request bit i counts only while enable bit i (`rdy_en_n[i]`) is 0. The qualified requests are ORed, so any one enabled high request is enough to raise `cpu_ready`.
- R2: A request whose enable is 1 never causes `cpu_ready` to be 1, whatever level it carries.
- R3: With `one_stage` = 0, a qualified request that rises after a rising clock edge makes `cpu_ready` go high at the second falling edge that follows. The path is the next rising edge, then the next falling edge.
- R4: With `one_stage` = 0, a qualified request that falls makes `cpu_ready` go low at the first falling edge after the change.
- R5: With `one_stage` = 1, both rising and falling qualified requests reach `cpu_ready` at the first falling edge after the change.
- R6: At each falling edge, `cpu_reset` takes the inverse of `rst_req_n`.
- R7: While `por_n` is 0, `cpu_ready` and `cpu_reset` are 0.
- R8: `cpu_ready` and `cpu_reset` update independently on the same falling edge. A ready drop and a reset assertion that arrive together both show up at that one edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock; both edges used |
| por_n | input | 1 | Active-low asynchronous power-up reset |
| rdy_req | input | NREQ | Asynchronous ready requests, high = transfer done |
| rdy_en_n | input | NREQ | Active-low enable for each request |
| one_stage | input | 1 | 1 = single synchronization, 0 = double synchronization |
| rst_req_n | input | 1 | Active-low reset request |
| cpu_ready | output | 1 | Synchronized ready to the processor |
| cpu_reset | output | 1 | Synchronized active-high processor reset |

## Verification
The ready output and the reset output are both driven by falling-edge flops, so they can change at the same edge. The bench provokes this by dropping the qualified ready request and the reset request together, just after a rising edge. It then expects, in the single sample taken after the next falling edge, `cpu_ready` low and `cpu_reset` high. A wrong edge or a coupling between the two paths shows up as a mismatch in that one slot.

// File: rtl/rdy_sync_pkg.sv
package rdy_sync_pkg;

  typedef enum logic {
    SYNC_DOUBLE = 1'b0,
    SYNC_SINGLE = 1'b1
  } sync_mode_e;

  // Next value of the falling-edge stage. A low request always passes
  // straight through; a high request waits for stage one in double mode.
  function automatic logic stage2_next(input sync_mode_e mode,
                                       input logic       stage1,
                                       input logic       qual);
    if (mode == SYNC_SINGLE) return qual;
    return stage1 & qual;
  endfunction

endpackage

// File: rtl/rdy_qualifier.sv
module rdy_qualifier #(
  parameter int NREQ = 2
) (
  input  logic [NREQ-1:0] req,
  input  logic [NREQ-1:0] en_n,
  output logic            qual
);
  logic [NREQ-1:0] hit;

  for (genvar i = 0; i < NREQ; i++) begin : g_hit
    assign hit[i] = req[i] & ~en_n[i];
  end

  assign qual = |hit;
endmodule

// File: rtl/rdy_sync_stages.sv
module rdy_sync_stages
  import rdy_sync_pkg::*;
(
  input  logic       clk,
  input  logic       por_n,
  input  sync_mode_e mode,
  input  logic       qual,
  output logic       stage1,
  output logic       stage2
);
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) stage1 <= 1'b0;
    else        stage1 <= qual;
  end

  always_ff @(negedge clk or negedge por_n) begin
    if (!por_n) stage2 <= 1'b0;
    else        stage2 <= stage2_next(mode, stage1, qual);
  end
endmodule

// File: rtl/rst_sync.sv
module rst_sync (
  input  logic clk,
  input  logic por_n,
  input  logic req_n,
  output logic rst_out
);
  always_ff @(negedge clk or negedge por_n) begin
    if (!por_n) rst_out <= 1'b0;
    else        rst_out <= ~req_n;
  end
endmodule

// File: rtl/bus_rdy_sync.sv
module bus_rdy_sync
  import rdy_sync_pkg::*;
#(
  parameter int NREQ = 2
) (
  input  logic            clk,
  input  logic            por_n,
  input  logic [NREQ-1:0] rdy_req,
  input  logic [NREQ-1:0] rdy_en_n,
  input  logic            one_stage,
  input  logic            rst_req_n,
  output logic            cpu_ready,
  output logic            cpu_reset
);
  // Named internal events, visible to the bound checker.
  logic       qual_w;
  logic       stage1_w;
  logic       stage2_w;
  sync_mode_e mode_w;

  assign mode_w = sync_mode_e'(one_stage);

  rdy_qualifier #(.NREQ(NREQ)) qual_i (
    .req  (rdy_req),
    .en_n (rdy_en_n),
    .qual (qual_w)
  );

  rdy_sync_stages stages_i (
    .clk    (clk),
    .por_n  (por_n),
    .mode   (mode_w),
    .qual   (qual_w),
    .stage1 (stage1_w),
    .stage2 (stage2_w)
  );

  rst_sync rst_i (
    .clk     (clk),
    .por_n   (por_n),
    .req_n   (rst_req_n),
    .rst_out (cpu_reset)
  );

  assign cpu_ready = stage2_w;
endmodule

// File: rtl/bus_rdy_sync_chk.sv
module bus_rdy_sync_chk (
  input logic clk,
  input logic por_n,
  input logic one_stage,
  input logic rst_req_n,
  input logic qual_w,
  input logic stage1_w,
  input logic cpu_ready,
  input logic cpu_reset
);
  AST_NO_READY_WITHOUT_REQ: assert property (@(negedge clk) disable iff (!por_n)
    !qual_w |=> !cpu_ready); // R2

  AST_DOUBLE_RISE_NEEDS_STAGE1: assert property (@(negedge clk) disable iff (!por_n)
    (!$past(one_stage) && $rose(cpu_ready)) |-> $past(stage1_w)); // R3

  AST_SINGLE_FOLLOWS_REQ: assert property (@(negedge clk) disable iff (!por_n)
    one_stage |=> (cpu_ready == $past(qual_w))); // R5

  AST_RESET_INVERTS_REQ: assert property (@(negedge clk) disable iff (!por_n)
    por_n |=> (cpu_reset == !$past(rst_req_n))); // R6

  always_comb begin
    if (!por_n) begin
      AST_POR_CLEARS: assert (!cpu_ready && !cpu_reset); // R7
    end
  end
endmodule

bind bus_rdy_sync bus_rdy_sync_chk chk_i (
  .clk       (clk),
  .por_n     (por_n),
  .one_stage (one_stage),
  .rst_req_n (rst_req_n),
  .qual_w    (qual_w),
  .stage1_w  (stage1_w),
  .cpu_ready (cpu_ready),
  .cpu_reset (cpu_reset)
);

// File: tb/bus_rdy_sync_tb_top.sv
module bus_rdy_sync_tb_top;
  localparam int NREQ = 2;

  logic            clk = 1'b0;
  logic            por_n;
  logic [NREQ-1:0] rdy_req;
  logic [NREQ-1:0] rdy_en_n;
  logic            one_stage;
  logic            rst_req_n;
  logic            cpu_ready;
  logic            cpu_reset;

  int checks = 0;
  int fails  = 0;

  typedef struct {
    logic  rdy;
    logic  rst;
    string tag;
  } exp_t;

  exp_t exp_q[$];
  logic exp_rdy = 1'b0;

  always #4 clk = ~clk; // 125 MHz

  bus_rdy_sync #(.NREQ(NREQ)) dut_i (
    .clk       (clk),
    .por_n     (por_n),
    .rdy_req   (rdy_req),
    .rdy_en_n  (rdy_en_n),
    .one_stage (one_stage),
    .rst_req_n (rst_req_n),
    .cpu_ready (cpu_ready),
    .cpu_reset (cpu_reset)
  );

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  // Monitor: one expected item per falling edge while the queue holds any.
  always begin
    @(negedge clk);
    #1;
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      check(e.tag, cpu_ready, e.rdy);
      check((e.tag == "R8") ? "R8" : "R6", cpu_reset, e.rst);
    end
  end

  // Driver: change inputs just after a rising edge and queue expectations.
  task automatic apply(input logic [NREQ-1:0] r, input logic [NREQ-1:0] en,
                       input logic rn, input logic m, input string force_tag);
    logic  q;
    string t;
    exp_t  e;
    int    n;
    @(posedge clk);
    #1;
    rdy_req   = r;
    rdy_en_n  = en;
    rst_req_n = rn;
    one_stage = m;
    q = |(r & ~en);
    if (q != exp_rdy) t = m ? "R5" : (q ? "R3" : "R4");
    else if (!q && ((r & en) != '0)) t = "R2";
    else t = "R1";
    if (force_tag != "") t = force_tag;
    n = 1;
    if (!m && q && !exp_rdy) begin
      e.rdy = 1'b0; e.rst = ~rn; e.tag = t;
      exp_q.push_back(e);
      n = 2;
    end
    e.rdy = q; e.rst = ~rn; e.tag = t;
    exp_q.push_back(e);
    repeat (n) @(negedge clk);
    #2;
    exp_rdy = q;
  endtask

  initial begin
    #1_000_000;
    checks++;
    fails++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    por_n     = 1'b0;
    rdy_req   = '0;
    rdy_en_n  = '1;
    one_stage = 1'b1;
    rst_req_n = 1'b0;
    #30;
    check("R7", cpu_ready, 1'b0);
    check("R7", cpu_reset, 1'b0);
    rst_req_n = 1'b1;
    @(posedge clk);
    #1;
    por_n = 1'b1;

    for (int mi = 1; mi >= 0; mi--) begin
      for (int ei = 0; ei < 4; ei++) begin
        logic [NREQ-1:0] en;
        en = NREQ'(ei);
        apply(2'b00, en, 1'b1, mi[0], "");
        apply(2'b01, en, 1'b1, mi[0], "");
        apply(2'b11, en, 1'b1, mi[0], "");
        apply(2'b00, en, 1'b1, mi[0], "");
        apply(2'b10, en, 1'b1, mi[0], "");
        apply(2'b10, en, 1'b1, mi[0], "");
        apply(2'b00, en, 1'b1, mi[0], "");
      end
    end

    // R6: reset request assert and release in both modes.
    apply(2'b00, 2'b11, 1'b0, 1'b1, "R6");
    apply(2'b00, 2'b11, 1'b1, 1'b1, "R6");
    apply(2'b00, 2'b11, 1'b0, 1'b0, "R6");
    apply(2'b00, 2'b11, 1'b1, 1'b0, "R6");

    // R8: ready drop and reset assertion land on the same falling edge.
    apply(2'b01, 2'b10, 1'b1, 1'b0, "R3");
    apply(2'b00, 2'b10, 1'b0, 1'b0, "R8");
    apply(2'b00, 2'b10, 1'b1, 1'b0, "R6");
    apply(2'b10, 2'b01, 1'b1, 1'b1, "R5");
    apply(2'b00, 2'b01, 1'b0, 1'b1, "R8");
    apply(2'b00, 2'b01, 1'b1, 1'b1, "R6");

    repeat (3) @(negedge clk);
    #3;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule